// File: doc/BRIEF.md
# Synchronous Burst Read Controller

This block is the device side of a clocked read path on a 16-bit host bus. It holds a 2K-word (4 KB) buffer RAM and a small configuration register. Out of reset the block behaves as an asynchronous-read device, and an address strobe starts nothing. Once software sets the burst-enable bit, a strobe taken on a rising clock edge captures a start address. The block then waits a programmable number of cycles and streams consecutive buffer words, one per clock.

A burst ends in one of three ways. A fixed-length burst ends after its word count. Raising chip enable ends any burst. A fresh strobe ends the current burst and starts a new one at once. Writes to the buffer and to the configuration register are single bus cycles and never start a burst. The output enable flag marks the cycles in which the external data pins would be driven. When it is low, the pads are left at high impedance.

Top module: `burst_read_ctrl`

## Requirements
- R1: After reset `dout_en` is low and the configuration reads as 16'h7000. This means burst mode is off, the latency is 7 and the length code is 000 (continuous).
- R2: While burst mode is off, a strobe (`adv_n` low with `cs_n` low) starts no burst, and `dout_en` stays low.
- R3: A clock edge with `cs_n` low and `we_n` low is a write. If `addr[11]`=0, `din` is stored in buffer word `addr[10:0]`. Address 12'h800 loads the whole configuration from `din`. Address 12'h801 loads only the burst-enable bit, from `din[15]`. A write never starts a burst, even with `adv_n` low.
- R4: The configuration fields are bit 15 for burst enable, bits [14:12] for latency L (0 to 7) and bits [11:9] for the length code. The length codes are: 000 continuous, 001 gives 4 words, 010 gives 8, 011 gives 16, 100 gives 32, and 101 to 111 are continuous.
- R5: A burst starts on an edge with `cs_n` low, `adv_n` low, `we_n` high, burst mode on and `addr[11]`=0, capturing `addr[10:0]`. A strobe with `addr[11]`=1 starts nothing.
- R6: If the start edge is E, `dout_en` stays low after edges E through E+L, and the word at the start address is on `dout` after edge E+L+1.
- R7: After the first word, each later rising edge presents the next word of the burst sequence.
- R8: A fixed-length burst of N words drops `dout_en` after edge E+L+N+1. A continuous burst runs until it is ended.
- R9: A fixed burst of N words wraps inside the N-aligned block that holds the start address. A continuous burst wraps from word 2047 to word 0.
- R10: `cs_n` high drops `dout_en` in the same cycle and ends the burst at the next edge. Lowering `cs_n` again does not resume that burst.
- R11: A new strobe during a burst abandons the old burst and restarts the timing of R6 from the new start edge.
- R12: `dout_en` is high only while `cs_n` is low, `oe_n` is low and a burst word is present. When it is low, `dout` is 0. Raising `oe_n` hides the data but does not pause the burst sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Hardware reset, active low |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | 12 | Word address; bit 11 selects register space |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, 0 when not enabled |
| dout_en | output | 1 | Output drive enable for the data pins |

## Verification
Each result has a fixed due cycle. A write takes effect at the edge it is presented on. The first burst word appears exactly L+1 edges after the start edge, each later word one edge after the previous one, and the drop of `dout_en` at the end of a fixed burst one edge after its last word. The output gating by `cs_n` and `oe_n` is combinational and is seen within the same cycle. The bench drives and samples just after falling edges and counts every rising edge from the start strobe. It checks that `dout_en` is low in each latency cycle and compares each word against an address sequence it derives from division and remainder rather than from bit masks.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef struct packed {
    logic       burst_en;
    logic [2:0] lat;
    logic [2:0] len_code;
  } brc_cfg_t;

  // Number of words in a fixed burst; 0 marks a continuous burst.
  function automatic int unsigned burst_words(logic [2:0] code);
    case (code)
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return 0;
    endcase
  endfunction

  // Next word address: wraps inside the len-aligned block, or at depth for len 0.
  function automatic int unsigned wrap_step(int unsigned ptr, int unsigned len,
                                            int unsigned depth);
    if (len == 0) return (ptr + 1) & (depth - 1);
    return (ptr & ~(len - 1)) | ((ptr + 1) & (len - 1));
  endfunction

endpackage

// File: rtl/brc_cfg_reg.sv
module brc_cfg_reg
  import brc_pkg::*;
#(
  parameter int LAT_RST = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we_full,
  input  logic     we_mode,
  input  logic [6:0] fields,   // din[15:9]
  output brc_cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.burst_en <= 1'b0;
      cfg.lat      <= 3'(LAT_RST);
      cfg.len_code <= 3'd0;
    end else if (we_full) begin
      cfg.burst_en <= fields[6];
      cfg.lat      <= fields[5:3];
      cfg.len_code <= fields[2:0];
    end else if (we_mode) begin
      cfg.burst_en <= fields[6];
    end
  end

endmodule

// File: rtl/brc_buffer_ram.sv
module brc_buffer_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/brc_sequencer.sv
module brc_sequencer
  import brc_pkg::*;
#(
  parameter int AW        = 11,
  parameter int MAX_BURST = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          reg_sel,
  input  logic [AW-1:0] addr_in,
  input  brc_cfg_t      cfg,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          data_valid
);

  localparam int CNT_W = $clog2(MAX_BURST) + 1;
  localparam int DEPTH = 1 << AW;

  logic             active;
  logic [2:0]       wait_cnt;
  logic [AW-1:0]    ptr;
  logic [CNT_W-1:0] issued;
  logic [CNT_W-1:0] blen_q;
  logic             valid_q;

  // Named events for the assertions.
  logic start_evt, len_done, issue_evt;
  logic [AW-1:0] ptr_next;

  assign start_evt = !cs_n && !adv_n && we_n && cfg.burst_en && !reg_sel;
  assign len_done  = (blen_q != '0) && (issued == blen_q);
  assign issue_evt = active && !cs_n && !start_evt && (wait_cnt == 3'd0) && !len_done;
  assign ptr_next  = AW'(wrap_step(32'(ptr), 32'(blen_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      wait_cnt <= 3'd0;
      ptr      <= '0;
      issued   <= '0;
      blen_q   <= '0;
      valid_q  <= 1'b0;
    end else if (start_evt) begin
      active   <= 1'b1;
      wait_cnt <= cfg.lat;
      ptr      <= addr_in;
      issued   <= '0;
      blen_q   <= CNT_W'(burst_words(cfg.len_code));
      valid_q  <= 1'b0;
    end else if (cs_n) begin
      active  <= 1'b0;
      valid_q <= 1'b0;
    end else if (active) begin
      if (wait_cnt != 3'd0) begin
        wait_cnt <= wait_cnt - 3'd1;
      end else if (issue_evt) begin
        ptr     <= ptr_next;
        issued  <= issued + CNT_W'(1);
        valid_q <= 1'b1;
      end else begin
        active  <= 1'b0;
        valid_q <= 1'b0;
      end
    end
  end

  assign rd_en      = issue_evt;
  assign rd_addr    = ptr;
  assign data_valid = valid_q;

  // R2: with burst mode off an idle sequencer stays idle
  a_r2_mode_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.burst_en && !active) |=> !active);

  // R3: a write cycle never launches a burst
  a_r3_write_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> !$rose(active));

  // R6: the first word only follows an exhausted latency count
  a_r6_word_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> ($past(active) && $past(wait_cnt) == 3'd0));

  // R8: a fixed burst never issues more words than its length
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && blen_q != '0) |-> (issued <= blen_q));

  // R10: chip enable high ends the burst at the next edge
  a_r10_ce_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!active && !valid_q));

  // R11: a restart withdraws the word of the old burst
  a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !valid_q);

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import brc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int AW        = 11,
  parameter int LAT_RST   = 7,
  parameter int MAX_BURST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              adv_n,
  input  logic [AW:0]       addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  brc_cfg_t          cfg;
  logic              reg_sel, wr_cyc, mem_we, cfg_we_full, cfg_we_mode;
  logic              rd_en, data_valid;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rdata;

  assign reg_sel     = addr[AW];
  assign wr_cyc      = !cs_n && !we_n;
  assign mem_we      = wr_cyc && !reg_sel;
  assign cfg_we_full = wr_cyc && reg_sel && !addr[0];
  assign cfg_we_mode = wr_cyc && reg_sel && addr[0];

  brc_cfg_reg #(.LAT_RST(LAT_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_full (cfg_we_full),
    .we_mode (cfg_we_mode),
    .fields  (din[15:9]),
    .cfg     (cfg)
  );

  brc_buffer_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr[AW-1:0]),
    .wdata (din),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  brc_sequencer #(.AW(AW), .MAX_BURST(MAX_BURST)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .adv_n      (adv_n),
    .we_n       (we_n),
    .reg_sel    (reg_sel),
    .addr_in    (addr[AW-1:0]),
    .cfg        (cfg),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .data_valid (data_valid)
  );

  assign dout_en = !cs_n && !oe_n && data_valid;
  assign dout    = dout_en ? rdata : '0;

  // R12: pads are driven only under both enables
  a_r12_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !oe_n));

  // R1: configuration holds its reset value until the first write
  a_r1_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(wr_cyc)) |-> (!cfg.burst_en && cfg.lat == 3'(LAT_RST)));

endmodule

// File: tb/burst_read_ctrl_test.sv
`timescale 1ns/1ps
module burst_read_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        dout_en;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  burst_read_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  // lat[22:20] code[19:17] start[16:6] count[5:0]
  localparam logic [22:0] VEC [7] = '{
    {3'd3, 3'd1, 11'd5,    6'd4},
    {3'd0, 3'd2, 11'd13,   6'd8},
    {3'd7, 3'd3, 11'd30,   6'd16},
    {3'd2, 3'd4, 11'd100,  6'd32},
    {3'd1, 3'd0, 11'd2045, 6'd6},
    {3'd4, 3'd6, 11'd50,   6'd5},
    {3'd5, 3'd1, 11'd0,    6'd4}
  };

  function automatic logic [15:0] exp_word(int a);
    return 16'(a * 7 + 'h1234);
  endfunction

  function automatic int len_of(int code);
    case (code)
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_addr(int start, int code, int k);
    int n = len_of(code);
    if (n == 0) return (start + k) % 2048;
    return (start / n) * n + ((start % n) + k) % n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_off(string req);
    chk(req, {15'd0, dout_en, dout}, 32'd0);
  endtask

  task automatic chk_word(string req, logic [15:0] w);
    chk(req, {15'd0, dout_en, dout}, {15'd0, 1'b1, w});
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic write(logic [11:0] a, logic [15:0] d, logic strobe);
    step();
    cs_n = 1'b0; we_n = 1'b0; adv_n = strobe ? 1'b0 : 1'b1; addr = a; din = d;
    step();
    we_n = 1'b1; adv_n = 1'b1;
  endtask

  // Returns just after the capture edge.
  task automatic start(logic [11:0] a);
    step();
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b0; addr = a;
    step();
    adv_n = 1'b1;
  endtask

  task automatic end_burst();
    step(); cs_n = 1'b1;
    step(); cs_n = 1'b0;
  endtask

  task automatic run_burst(int sa, int lat, int code, int cnt);
    start(12'(sa));
    chk_off("R6 latency");
    for (int i = 1; i <= lat; i++) begin
      step();
      chk_off("R6 latency");
    end
    for (int k = 0; k < cnt; k++) begin
      step();
      chk_word("R7 R9 sequence", exp_word(exp_addr(sa, code, k)));
    end
    if (len_of(code) != 0) begin
      step();
      chk_off("R8 length end");
    end
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk_off("R1 reset output");

    // Fill the buffer (R3).
    for (int i = 0; i < 2048; i++) write(12'(i), exp_word(i), 1'b0);

    // R2: mode off, strobe starts nothing.
    start(12'd40);
    for (int i = 0; i < 10; i++) begin
      chk_off("R2 mode off");
      step();
    end

    // R1: enable only the mode bit; default latency 7 and continuous.
    end_burst();
    write(12'h801, 16'h8000, 1'b0);
    run_burst(10, 7, 0, 3);
    end_burst();

    // R4 R6 R7 R8 R9 over the table.
    for (int v = 0; v < 7; v++) begin
      int lat  = int'(VEC[v][22:20]);
      int code = int'(VEC[v][19:17]);
      int sa   = int'(VEC[v][16:6]);
      int cnt  = int'(VEC[v][5:0]);
      write(12'h800, {1'b1, 3'(lat), 3'(code), 9'd0}, 1'b0);
      run_burst(sa, lat, code, cnt);
      end_burst();
    end

    // R10: chip enable high ends the burst.
    write(12'h800, {1'b1, 3'd0, 3'd0, 9'd0}, 1'b0);
    start(12'd300);
    chk_off("R6 latency");
    step();
    chk_word("R7 first", exp_word(300));
    cs_n = 1'b1;
    #1;
    chk_off("R10 immediate");
    step();
    cs_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk_off("R10 no resume");
    end

    // R11: restart mid-burst.
    write(12'h800, {1'b1, 3'd1, 3'd0, 9'd0}, 1'b0);
    run_burst(100, 1, 0, 2);
    start(12'd500);
    chk_off("R11 old burst dropped");
    step();
    chk_off("R11 new latency");
    step();
    chk_word("R11 new start", exp_word(500));
    step();
    chk_word("R11 next", exp_word(501));
    end_burst();

    // R12: oe_n high hides data, sequence keeps running.
    write(12'h800, {1'b1, 3'd0, 3'd0, 9'd0}, 1'b0);
    start(12'd200);
    chk_off("R6 latency");
    step();
    chk_word("R12 first", exp_word(200));
    oe_n = 1'b1;
    #1;
    chk_off("R12 oe high");
    step();
    chk_off("R12 oe high");
    step();
    chk_off("R12 oe high");
    oe_n = 1'b0;
    #1;
    chk_word("R12 not paused", exp_word(202));
    step();
    chk_word("R12 next", exp_word(203));
    end_burst();

    // R5: strobe in register space starts nothing.
    start(12'h805);
    for (int i = 0; i < 4; i++) begin
      chk_off("R5 register space");
      step();
    end
    end_burst();

    // R3: write with strobe low stores data and starts nothing.
    write(12'h800, {1'b1, 3'd0, 3'd1, 9'd0}, 1'b0);
    write(12'd20, 16'hBEEF, 1'b1);
    chk_off("R3 write no start");
    step();
    chk_off("R3 write no start");
    start(12'd20);
    chk_off("R6 latency");
    step();
    chk_word("R3 stored word", 16'hBEEF);
    step();
    chk_word("R9 fixed wrap", exp_word(21));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule